// File: doc/BRIEF.md
# DRAM Row-Buffer Command Sequencer

This block sits between a cacheline request source and a single-rank DRAM command port. Each request names a 64-byte line and whether it is a read or a write. The block splits that line number into a channel, a bank, a row and a column. Which address bits form the bank and the row is set by a layout select, and the select can be changed at run time. For every channel/bank pair the block records whether a row is open and which row it is. It then issues the precharge, activate and column commands that the request needs, one command per cycle, and never breaks the minimum spacing between commands to the same bank.

Requests are handled strictly in order, one at a time, through a valid/ready handshake. When a request has finished, the block pulses a response that carries the decoded channel, bank and row. The response also says whether the access hit an open row, found the bank idle, or conflicted with another open row, and it gives the number of cycles from acceptance to completion. Changing the layout select has an effect only between requests. Before the new layout is used, every open row is closed. The spacing counters of each bank keep running while other banks are being served.

Top module: `rowbuf_ctrl`

## Requirements
- R1: With layout select 0 (interleaved), the line address `L` decodes as follows: channel = `L[0]`, bank = `L[3:1]`, column = `L[10:4]`, row = the bits above bit 10. With the default widths this means the bank pattern repeats every 16 lines and a new row starts every 2048 lines.
- R2: With layout select 1 (contiguous), the line address decodes as follows: channel = `L[0]`, column = `L[7:1]`, row = `L[7+ROW_W:8]`, bank = the top bits. Two lines on the same channel and in the same 256-line block therefore always share one row.
- R3: A request whose bank already holds the addressed row is served by a single column command. Its response reports kind 0 (hit) and latency T_CL, which is 4 by default.
- R4: A request to a bank with no open row is served by an activate and then a column command. Its response reports kind 1 (miss) and latency T_RCD+T_CL, which is 11 by default.
- R5: A request that finds a different row open is served by a precharge, an activate and a column command. The activate comes at least T_RP (11) cycles after the precharge. The response reports kind 2 (conflict) and latency 22 by default.
- R6: If a write column command reached a bank after its row was opened, closing that row adds T_WR (4) cycles before the next activate. A read conflict that follows such a write therefore reports latency 26.
- R7: A column command to a bank is issued no earlier than T_RCD (7) cycles after that bank's activate.
- R8: At most one request is in flight. `req_ready` is low from the cycle after acceptance until the response. `resp_valid` is a single-cycle pulse. Commands on `cmd_op` are encoded 0 = precharge, 1 = activate, 2 = read, 3 = write.
- R9: The layout select is sampled only while the block is idle. When the select differs from the layout in use, `req_ready` stays low while every open row is closed, with one precharge per cycle, and only then does the new layout take effect. A request already accepted completes under the layout it was accepted with.
- R10: Bank spacing counters keep running across requests. An activate to a bank that a mode change has just closed waits for that bank's remaining precharge spacing, and the response latency grows by exactly that wait.
- R11: After reset all banks are closed, the interleaved layout is in use, `req_ready` is high, and neither a command nor a response is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | Layout select: 0 interleaved, 1 contiguous |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_line | input | LINE_AW | Cacheline address |
| cmd_valid | output | 1 | A command is presented this cycle |
| cmd_op | output | 2 | Command code (R8) |
| cmd_chan | output | 1 | Channel of the command |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_row | output | ROW_W | Row for activate and column commands |
| cmd_col | output | COL_W | Column for column commands |
| resp_valid | output | 1 | Completion pulse |
| resp_chan | output | 1 | Decoded channel |
| resp_bank | output | BANK_W | Decoded bank |
| resp_row | output | ROW_W | Decoded row |
| resp_kind | output | 2 | 0 hit, 1 miss, 2 conflict |
| resp_lat | output | LAT_W | Cycles from acceptance to completion |

## Verification
The bench builds the block with ROW_W set to 6 and keeps the default bank, column and timing values, so the line address is 17 bits wide. With this setting the top line of the address space falls in the highest bank and row in both layouts. The smaller row field also lets a single short table open rows in the first and last slot of both channels. Because the timing values stay at their defaults, the latencies of 4, 11, 22 and 26 cycles can be checked exactly. So can the 24-cycle case in which a dirty bank that was precharged during a mode change is activated again straight away.

// File: rtl/rb_pkg.sv
package rb_pkg;
  typedef enum logic [1:0] {
    OP_PRE = 2'd0,
    OP_ACT = 2'd1,
    OP_RD  = 2'd2,
    OP_WR  = 2'd3
  } rb_op_e;

  typedef enum logic [1:0] {
    KIND_HIT  = 2'd0,
    KIND_MISS = 2'd1,
    KIND_CONF = 2'd2
  } rb_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_WACT,
    ST_WCOL,
    ST_WDONE
  } rb_state_e;

  localparam logic MAP_ILV    = 1'b0;
  localparam logic MAP_CONTIG = 1'b1;
endpackage

// File: rtl/rb_addr_map.sv
module rb_addr_map #(
  parameter int BANK_W = 3,
  parameter int COL_W  = 7,
  parameter int ROW_W  = 15,
  parameter int LINE_AW = 1 + BANK_W + COL_W + ROW_W
) (
  input  logic [LINE_AW-1:0] line,
  input  logic               mode,
  output logic               chan,
  output logic [BANK_W-1:0]  bank,
  output logic [ROW_W-1:0]   row,
  output logic [COL_W-1:0]   col
);
  import rb_pkg::*;

  // interleaved layout: channel, bank, column, row from low to high
  localparam int I_BANK_LO = 1;
  localparam int I_COL_LO  = I_BANK_LO + BANK_W;
  localparam int I_ROW_LO  = I_COL_LO + COL_W;
  // contiguous layout: channel, column, row, bank from low to high
  localparam int C_COL_LO  = 1;
  localparam int C_ROW_LO  = C_COL_LO + COL_W;
  localparam int C_BANK_LO = C_ROW_LO + ROW_W;

  logic [BANK_W-1:0] i_bank, c_bank;
  logic [ROW_W-1:0]  i_row,  c_row;
  logic [COL_W-1:0]  i_col,  c_col;

  assign i_bank = line[I_BANK_LO +: BANK_W];
  assign i_col  = line[I_COL_LO  +: COL_W];
  assign i_row  = line[I_ROW_LO  +: ROW_W];
  assign c_col  = line[C_COL_LO  +: COL_W];
  assign c_row  = line[C_ROW_LO  +: ROW_W];
  assign c_bank = line[C_BANK_LO +: BANK_W];

  always_comb begin
    chan = line[0];
    if (mode == MAP_CONTIG) begin
      bank = c_bank;
      row  = c_row;
      col  = c_col;
    end else begin
      bank = i_bank;
      row  = i_row;
      col  = i_col;
    end
  end
endmodule

// File: rtl/rb_bank_slot.sv
module rb_bank_slot #(
  parameter int ROW_W = 15,
  parameter int T_RP  = 11,
  parameter int T_WR  = 4,
  parameter int T_RCD = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             do_pre,
  input  logic             do_act,
  input  logic             do_col,
  input  logic             col_wr,
  input  logic [ROW_W-1:0] act_row,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic             act_ok,
  output logic             col_ok
);
  localparam int TMR_W = $clog2(T_RP + T_WR + T_RCD + 1);

  logic             open_q;
  logic             dirty_q;
  logic [ROW_W-1:0] row_q;
  logic [TMR_W-1:0] act_tmr;
  logic [TMR_W-1:0] col_tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q  <= 1'b0;
      dirty_q <= 1'b0;
      row_q   <= '0;
      act_tmr <= '0;
      col_tmr <= '0;
    end else begin
      if (act_tmr != '0) act_tmr <= act_tmr - 1'b1;
      if (col_tmr != '0) col_tmr <= col_tmr - 1'b1;
      if (do_pre) begin
        open_q  <= 1'b0;
        dirty_q <= 1'b0;
        act_tmr <= dirty_q ? TMR_W'(T_RP + T_WR - 1) : TMR_W'(T_RP - 1);
      end
      if (do_act) begin
        open_q  <= 1'b1;
        row_q   <= act_row;
        col_tmr <= TMR_W'(T_RCD - 1);
      end
      if (do_col && col_wr) dirty_q <= 1'b1;
    end
  end

  assign is_open  = open_q;
  assign open_row = row_q;
  assign act_ok   = (act_tmr == '0);
  assign col_ok   = (col_tmr == '0);

  // R4: an activate only lands on a closed bank
  p_act_closed_r4: assert property (@(posedge clk) disable iff (rst)
    do_act |-> !open_q);
  // R5: a precharge only targets an open row
  p_pre_open_r5: assert property (@(posedge clk) disable iff (rst)
    do_pre |-> open_q);
  // R7: column commands need an open row and expired activate spacing
  p_col_open_r7: assert property (@(posedge clk) disable iff (rst)
    do_col |-> (open_q && col_tmr == '0));
  // R5: a row opens only through an activate
  p_open_by_act_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(open_q) |-> $past(do_act));
endmodule

// File: rtl/rowbuf_ctrl.sv
module rowbuf_ctrl #(
  parameter int BANK_W = 3,
  parameter int COL_W  = 7,
  parameter int ROW_W  = 15,
  parameter int T_RP   = 11,
  parameter int T_WR   = 4,
  parameter int T_RCD  = 7,
  parameter int T_CL   = 4,
  parameter int LAT_W  = 8,
  parameter int LINE_AW = 1 + BANK_W + COL_W + ROW_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode_sel,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [LINE_AW-1:0] req_line,
  output logic               cmd_valid,
  output logic [1:0]         cmd_op,
  output logic               cmd_chan,
  output logic [BANK_W-1:0]  cmd_bank,
  output logic [ROW_W-1:0]   cmd_row,
  output logic [COL_W-1:0]   cmd_col,
  output logic               resp_valid,
  output logic               resp_chan,
  output logic [BANK_W-1:0]  resp_bank,
  output logic [ROW_W-1:0]   resp_row,
  output logic [1:0]         resp_kind,
  output logic [LAT_W-1:0]   resp_lat
);
  import rb_pkg::*;

  localparam int SLOT_W = BANK_W + 1;
  localparam int NSLOT  = 1 << SLOT_W;
  localparam int DONE_W = $clog2(T_CL + 1);

  // decode of the incoming request under the layout in use
  logic              cur_mode;
  logic              d_chan;
  logic [BANK_W-1:0] d_bank;
  logic [ROW_W-1:0]  d_row;
  logic [COL_W-1:0]  d_col;
  logic [SLOT_W-1:0] d_slot;

  rb_addr_map #(
    .BANK_W(BANK_W), .COL_W(COL_W), .ROW_W(ROW_W), .LINE_AW(LINE_AW)
  ) u_map (
    .line(req_line), .mode(cur_mode),
    .chan(d_chan), .bank(d_bank), .row(d_row), .col(d_col)
  );
  assign d_slot = {d_chan, d_bank};

  // per channel/bank row-buffer state
  logic [NSLOT-1:0] slot_open, slot_act_ok, slot_col_ok;
  logic [NSLOT-1:0] pre_vec, act_vec, col_vec;
  logic [ROW_W-1:0] slot_row [NSLOT];

  logic              iss_pre, iss_act, iss_col;
  logic [SLOT_W-1:0] iss_slot;
  logic [ROW_W-1:0]  iss_row;
  logic [COL_W-1:0]  iss_coladdr;
  logic              iss_wr;

  assign pre_vec = iss_pre ? (NSLOT'(1) << iss_slot) : '0;
  assign act_vec = iss_act ? (NSLOT'(1) << iss_slot) : '0;
  assign col_vec = iss_col ? (NSLOT'(1) << iss_slot) : '0;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    rb_bank_slot #(
      .ROW_W(ROW_W), .T_RP(T_RP), .T_WR(T_WR), .T_RCD(T_RCD)
    ) u_slot (
      .clk(clk), .rst(rst),
      .do_pre(pre_vec[g]), .do_act(act_vec[g]), .do_col(col_vec[g]),
      .col_wr(iss_wr), .act_row(iss_row),
      .is_open(slot_open[g]), .open_row(slot_row[g]),
      .act_ok(slot_act_ok[g]), .col_ok(slot_col_ok[g])
    );
  end

  // lowest open slot, used when closing rows for a layout change
  logic [SLOT_W-1:0] low_slot;
  always_comb begin
    low_slot = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (slot_open[i]) low_slot = SLOT_W'(i);
    end
  end

  // classification of the incoming request
  rb_kind_e d_kind;
  always_comb begin
    if (!slot_open[d_slot])               d_kind = KIND_MISS;
    else if (slot_row[d_slot] == d_row)   d_kind = KIND_HIT;
    else                                  d_kind = KIND_CONF;
  end

  // request held while in flight
  rb_state_e         st, st_d;
  logic [SLOT_W-1:0] r_slot;
  logic [ROW_W-1:0]  r_row;
  logic [COL_W-1:0]  r_col;
  logic              r_wr;
  rb_kind_e          r_kind;
  logic [DONE_W-1:0] done_cnt;
  logic [LAT_W-1:0]  lat_cnt;

  logic acc, flush_done, resp_fire;

  assign req_ready = (st == ST_IDLE) && (mode_sel == cur_mode);

  always_comb begin
    st_d       = st;
    iss_pre    = 1'b0;
    iss_act    = 1'b0;
    iss_col    = 1'b0;
    iss_slot   = r_slot;
    acc        = 1'b0;
    flush_done = 1'b0;
    resp_fire  = 1'b0;
    case (st)
      ST_IDLE: begin
        if (mode_sel != cur_mode) begin
          st_d = ST_FLUSH;
        end else if (req_valid) begin
          acc      = 1'b1;
          iss_slot = d_slot;
          case (d_kind)
            KIND_HIT: begin
              if (slot_col_ok[d_slot]) begin
                iss_col = 1'b1;
                st_d    = ST_WDONE;
              end else begin
                st_d = ST_WCOL;
              end
            end
            KIND_MISS: begin
              if (slot_act_ok[d_slot]) begin
                iss_act = 1'b1;
                st_d    = ST_WCOL;
              end else begin
                st_d = ST_WACT;
              end
            end
            default: begin
              iss_pre = 1'b1;
              st_d    = ST_WACT;
            end
          endcase
        end
      end
      ST_FLUSH: begin
        if (slot_open != '0) begin
          iss_pre  = 1'b1;
          iss_slot = low_slot;
        end else begin
          flush_done = 1'b1;
          st_d       = ST_IDLE;
        end
      end
      ST_WACT: begin
        if (slot_act_ok[r_slot]) begin
          iss_act = 1'b1;
          st_d    = ST_WCOL;
        end
      end
      ST_WCOL: begin
        if (slot_col_ok[r_slot]) begin
          iss_col = 1'b1;
          st_d    = ST_WDONE;
        end
      end
      ST_WDONE: begin
        if (done_cnt == '0) begin
          resp_fire = 1'b1;
          st_d      = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign iss_row     = (st == ST_IDLE) ? d_row : r_row;
  assign iss_coladdr = (st == ST_IDLE) ? d_col : r_col;
  assign iss_wr      = (st == ST_IDLE) ? req_write : r_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cur_mode <= MAP_ILV;
      r_slot   <= '0;
      r_row    <= '0;
      r_col    <= '0;
      r_wr     <= 1'b0;
      r_kind   <= KIND_HIT;
      done_cnt <= '0;
      lat_cnt  <= '0;
    end else begin
      st <= st_d;
      if (flush_done) cur_mode <= mode_sel;
      if (acc) begin
        r_slot <= d_slot;
        r_row  <= d_row;
        r_col  <= d_col;
        r_wr   <= req_write;
        r_kind <= d_kind;
      end
      if (iss_col)              done_cnt <= DONE_W'(T_CL - 1);
      else if (done_cnt != '0)  done_cnt <= done_cnt - 1'b1;
      if (acc)                  lat_cnt <= LAT_W'(1);
      else if (lat_cnt != '1)   lat_cnt <= lat_cnt + 1'b1;
    end
  end

  // registered command port
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_op    <= OP_PRE;
      cmd_chan  <= 1'b0;
      cmd_bank  <= '0;
      cmd_row   <= '0;
      cmd_col   <= '0;
    end else begin
      cmd_valid <= iss_pre | iss_act | iss_col;
      cmd_chan  <= iss_slot[SLOT_W-1];
      cmd_bank  <= iss_slot[BANK_W-1:0];
      cmd_row   <= iss_row;
      cmd_col   <= iss_coladdr;
      if (iss_pre)      cmd_op <= OP_PRE;
      else if (iss_act) cmd_op <= OP_ACT;
      else if (iss_wr)  cmd_op <= OP_WR;
      else              cmd_op <= OP_RD;
    end
  end

  // registered completion port
  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_chan  <= 1'b0;
      resp_bank  <= '0;
      resp_row   <= '0;
      resp_kind  <= KIND_HIT;
      resp_lat   <= '0;
    end else begin
      resp_valid <= resp_fire;
      if (resp_fire) begin
        resp_chan <= r_slot[SLOT_W-1];
        resp_bank <= r_slot[BANK_W-1:0];
        resp_row  <= r_row;
        resp_kind <= r_kind;
        resp_lat  <= lat_cnt;
      end
    end
  end

  // R8: busy after accepting, single-cycle completion
  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  p_resp_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);
  // R3: a hit completes after the column latency only
  p_hit_lat_r3: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_kind == KIND_HIT) |-> resp_lat == LAT_W'(T_CL));
  // R5: a conflict pays at least precharge, activate and column latency
  p_conf_lat_r5: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_kind == KIND_CONF) |-> resp_lat >= LAT_W'(T_RP + T_RCD + T_CL));
  // R9: layout changes only once every row is closed
  p_mode_switch_r9: assert property (@(posedge clk) disable iff (rst)
    (cur_mode != $past(cur_mode)) |-> ($past(slot_open) == '0));
endmodule

// File: tb/sim_rowbuf_ctrl.sv
module sim_rowbuf_ctrl;
  localparam int BANK_W = 3;
  localparam int COL_W  = 7;
  localparam int ROW_W  = 6;
  localparam int LAW    = 1 + BANK_W + COL_W + ROW_W;  // 17
  localparam int NV     = 14;

  // {write, mode, line[16:0], kind[1:0], latency[7:0]}
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 1'b0, 17'h00000, 2'd1, 8'd11},  // R4 first access ch0 b0
    {1'b0, 1'b0, 17'h00010, 2'd0, 8'd4 },  // R3 same row, next column
    {1'b0, 1'b0, 17'h00002, 2'd1, 8'd11},  // R1 next bank
    {1'b0, 1'b0, 17'h00001, 2'd1, 8'd11},  // R1 other channel
    {1'b0, 1'b0, 17'h00800, 2'd2, 8'd22},  // R5 row 1 in bank 0
    {1'b1, 1'b0, 17'h00810, 2'd0, 8'd4 },  // R3 write hit
    {1'b0, 1'b0, 17'h00000, 2'd2, 8'd26},  // R6 conflict after write
    {1'b1, 1'b0, 17'h0000E, 2'd1, 8'd11},  // R1 bank 7
    {1'b0, 1'b0, 17'h1FFFF, 2'd1, 8'd11},  // R1 top line
    {1'b0, 1'b1, 17'h00000, 2'd1, 8'd11},  // R9 closed by layout change
    {1'b0, 1'b1, 17'h00002, 2'd0, 8'd4 },  // R2 neighbour line same row
    {1'b0, 1'b1, 17'h00100, 2'd2, 8'd22},  // R2 next row
    {1'b0, 1'b1, 17'h04000, 2'd1, 8'd11},  // R2 bank 1
    {1'b1, 1'b1, 17'h1C001, 2'd1, 8'd11}   // R2 top bank ch1
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             mode_sel = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_write = 1'b0;
  logic [LAW-1:0]   req_line = '0;
  logic             req_ready;
  logic             cmd_valid;
  logic [1:0]       cmd_op;
  logic             cmd_chan;
  logic [BANK_W-1:0] cmd_bank;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;
  logic             resp_valid;
  logic             resp_chan;
  logic [BANK_W-1:0] resp_bank;
  logic [ROW_W-1:0] resp_row;
  logic [1:0]       resp_kind;
  logic [7:0]       resp_lat;

  rowbuf_ctrl #(.ROW_W(ROW_W)) u0 (
    .clk(clk), .rst(rst), .mode_sel(mode_sel),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_line(req_line),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_chan(cmd_chan),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .resp_valid(resp_valid), .resp_chan(resp_chan), .resp_bank(resp_bank),
    .resp_row(resp_row), .resp_kind(resp_kind), .resp_lat(resp_lat)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int cmd_total = 0;
  int pre_total = 0;
  int space_viol = 0;
  int last_pre [16];
  int last_act [16];
  int gap_need [16];
  bit wr_since [16];
  bit done_flag = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // command monitor: spacing per channel/bank from R5, R6, R7
  always @(negedge clk) begin
    if (!rst && cmd_valid) begin
      automatic int s = {cmd_chan, cmd_bank};
      cmd_total++;
      case (cmd_op)
        2'd0: begin
          pre_total++;
          last_pre[s] = cyc;
          gap_need[s] = wr_since[s] ? 15 : 11;
          wr_since[s] = 0;
        end
        2'd1: begin
          if (cyc - last_pre[s] < gap_need[s]) space_viol++;
          last_act[s] = cyc;
        end
        default: begin
          if (cyc - last_act[s] < 7) space_viol++;
          if (cmd_op == 2'd3) wr_since[s] = 1;
        end
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // expected decode from R1 / R2 (bench widths: ROW_W = 6)
  task automatic decode(input logic [LAW-1:0] ln, input logic m,
                        output int ch, output int bk, output int rw);
    ch = int'(ln[0]);
    if (m) begin
      bk = int'(ln[16:14]);
      rw = int'(ln[13:8]);
    end else begin
      bk = int'(ln[3:1]);
      rw = int'(ln[16:11]);
    end
  endtask

  task automatic do_req(input logic wr, input logic [LAW-1:0] ln, input logic dmode,
                        input int ekind, input int elat, input string ktag,
                        input string dtag, input bit flip);
    int ech, ebk, erw, n, c0, ncmd;
    decode(ln, dmode, ech, ebk, erw);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_line  = ln;
    n = 0;
    while (!req_ready) begin
      @(negedge clk);
      n++;
      if (n > 400) begin
        chk(0, "R8", "ready timeout", 0, 1);
        finish_run();
      end
    end
    c0 = cmd_total;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (flip) mode_sel = ~mode_sel;
    chk(req_ready == 1'b0, "R8", "ready after accept", int'(req_ready), 0);
    n = 0;
    while (1) begin
      if (n != 0) @(negedge clk);
      if (resp_valid) break;
      @(posedge clk);
      n++;
      if (n > 400) begin
        chk(0, ktag, "response timeout", n, elat);
        finish_run();
      end
    end
    // n counts clock edges from acceptance to the response edge
    ncmd = cmd_total - c0;
    chk(int'(resp_kind) == ekind, ktag, "kind", int'(resp_kind), ekind);
    chk(int'(resp_lat) == elat, ktag, "reported latency", int'(resp_lat), elat);
    chk(n == elat, ktag, "observed latency", n, elat);
    chk(ncmd == ekind + 1, ktag, "command count", ncmd, ekind + 1);
    chk(int'(resp_chan) == ech, dtag, "channel", int'(resp_chan), ech);
    chk(int'(resp_bank) == ebk, dtag, "bank", int'(resp_bank), ebk);
    chk(int'(resp_row) == erw, dtag, "row", int'(resp_row), erw);
    @(negedge clk);
    chk(resp_valid == 1'b0, "R8", "response pulse width", int'(resp_valid), 0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    chk(0, "ALL", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      last_pre[i] = -1000;
      last_act[i] = -1000;
      gap_need[i] = 0;
      wr_since[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk(req_ready == 1'b1, "R11", "ready after reset", int'(req_ready), 1);
    chk(resp_valid == 1'b0, "R11", "resp after reset", int'(resp_valid), 0);
    chk(cmd_valid == 1'b0, "R11", "cmd after reset", int'(cmd_valid), 0);

    for (int v = 0; v < NV; v++) begin
      automatic logic [28:0] e = VEC[v];
      automatic logic vwr = e[28];
      automatic logic vmode = e[27];
      automatic logic [LAW-1:0] vline = e[26:10];
      automatic int vkind = int'(e[9:8]);
      automatic int vlat = int'(e[7:0]);
      automatic string kt = (vlat == 26) ? "R6" : (vkind == 0) ? "R3" :
                            (vkind == 1) ? "R4" : "R5";
      automatic string dt = vmode ? "R2" : "R1";
      if (vmode != mode_sel) begin
        automatic int p0 = pre_total;
        @(negedge clk);
        mode_sel = vmode;
        repeat (40) @(negedge clk);
        // R9: five rows were open (ch0 b0,b1,b7 and ch1 b0,b7)
        chk(pre_total - p0 == 5, "R9", "precharges on layout change", pre_total - p0, 5);
        chk(req_ready == 1'b1, "R9", "ready after close", int'(req_ready), 1);
      end
      do_req(vwr, vline, vmode, vkind, vlat, kt, dt, 1'b0);
      repeat (2) @(negedge clk);
    end

    // R9: select flips while a request is in flight; old layout still applies
    do_req(1'b0, 17'h04000, 1'b1, 0, 4, "R9", "R9", 1'b1);
    // R10: immediately afterwards, ch1 b7 was dirty and is precharged last
    begin
      automatic int p0 = pre_total;
      do_req(1'b0, 17'h0000F, 1'b0, 1, 24, "R10", "R1", 1'b0);
      chk(pre_total - p0 == 3, "R9", "precharges on second change", pre_total - p0, 3);
    end
    repeat (4) @(negedge clk);
    chk(space_viol == 0, "R5", "activate spacing violations", space_viol, 0);
    chk(space_viol == 0, "R7", "column spacing violations", space_viol, 0);
    finish_run();
  end
endmodule